// File: doc/BRIEF.md
# Prioritised Interrupt Level Evaluator

This block merges two request sources into one interrupt priority level. The first source is a software request register held inside the block. The second is a small vector of external request lines. Both sources share one level scale. Each software bit maps to a low level, counted up from one. Each external line maps to a level equal to its own summary bit index, so every external level sits above every software level. From the two sources the block forms the highest pending level and a summary mask that holds every pending request at its own bit position.

An evaluate strobe compares that level against a priority threshold register. When the level is nonzero and strictly above the threshold, the block raises a take request in the same cycle. On the next clock edge it latches the mask into a summary register and the level into an interrupt-ID register.

A small write port loads the internal registers. The port masks each register to its legal field, rejects writes to the read-only ID register with a fault pulse, and holds a trap-request register that has no support. That register raises an error output while it is nonzero. Delivering the trap is left to the surrounding logic.

Top module: `irq_level_eval`

## Requirements
- R1: With no external line set, the pending level is the highest set software bit i (bits 4 to 18) mapped to i - 3, so bit 4 gives level 1 and bit 18 gives level 15.
- R2: External line j (j = 0 to 3) stands for level 20 + j. The highest set line sets the level, and any set line overrides every software level.
- R3: The pending mask holds each set software bit i at bit i and each set external line j at bit 20 + j, with all other bits zero.
- R4: `take_o` is high in the strobe cycle exactly when the pending level is nonzero and strictly greater than the threshold register. It is low whenever `strobe_i` is low.
- R5: In a cycle with `take_o` high, the next clock edge loads `summary_o` with the pending mask and `int_id_o` with the pending level.
- R6: `summary_o` and `int_id_o` keep their values across every edge where `take_o` was low.
- R7: A write with `wr_sel_i` = 0 loads the software request register with `wr_data_i & 0x7fff0`. The result is visible on `sw_req_o` after the edge.
- R8: A write with `wr_sel_i` = 1 loads the threshold register with the low 5 bits of `wr_data_i`. The result is visible on `prio_o`.
- R9: A write with `wr_sel_i` = 2 targets the read-only ID register. It raises `wr_fault_o` in that cycle and leaves `int_id_o` and every other register unchanged.
- R10: A write with `wr_sel_i` = 3 loads the trap-request register with the low 4 bits of `wr_data_i`. `async_err_o` is high exactly while that register is nonzero.
- R11: After reset, the outputs `summary_o`, `int_id_o`, `sw_req_o`, `prio_o`, `take_o`, `wr_fault_o` and `async_err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 2 | Write target: 0 software requests, 1 threshold, 2 ID (read-only), 3 trap request |
| wr_data_i | input | 32 | Write data |
| ext_req_i | input | 4 | External request lines, line j stands for level 20 + j |
| strobe_i | input | 1 | Evaluate strobe |
| take_o | output | 1 | Interrupt take request (combinational in the strobe cycle) |
| summary_o | output | 24 | Latched summary mask |
| int_id_o | output | 5 | Latched interrupt level |
| sw_req_o | output | 32 | Software request register contents |
| prio_o | output | 5 | Threshold register contents |
| wr_fault_o | output | 1 | Fault for a write to the read-only ID register |
| async_err_o | output | 1 | Unsupported trap request is pending |

## Verification
A wrong level encoding or a wrong source priority shows in the strobe cycle itself: `take_o` flips at the threshold boundary, and one edge later `int_id_o` carries the wrong value. A register that is masked wrongly shows on `sw_req_o` or `prio_o` right after the write edge. The same fault shows later as extra bits in `summary_o`, or as a take decision that moves at the next strobe. A status register that fails to hold shows on the first non-taken strobe, because `summary_o` or `int_id_o` then changes.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;
   typedef enum logic [1:0] {
      SEL_SWREQ = 2'd0,
      SEL_PRIO  = 2'd1,
      SEL_ID    = 2'd2,
      SEL_ASYNC = 2'd3
   } wr_sel_e;
endpackage

// File: rtl/irq_hi_encode.sv
module irq_hi_encode #(
   parameter int W     = 15,
   parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     vec_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   if (W < 1) begin : g_bad_w
      $error("irq_hi_encode: W must be at least 1");
   end

   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = 0; i < W; i++) begin
         if (vec_i[i]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_level_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SW_MIN  = 4,
   parameter int SW_MAX  = 19,
   parameter int LVL_W   = 5,
   parameter int ASYNC_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  wr_sel_e           wr_sel_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] sw_q_o,
   output logic [LVL_W-1:0]  prio_q_o,
   output logic [ASYNC_W-1:0] async_q_o,
   output logic              wr_fault_o
);
   logic [DATA_W-1:0] sw_mask;

   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         sw_mask[i] = (i >= SW_MIN) && (i < SW_MAX);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sw_q_o    <= '0;
         prio_q_o  <= '0;
         async_q_o <= '0;
      end else if (wr_en_i) begin
         case (wr_sel_i)
            SEL_SWREQ: sw_q_o    <= wr_data_i & sw_mask;
            SEL_PRIO:  prio_q_o  <= wr_data_i[LVL_W-1:0];
            SEL_ASYNC: async_q_o <= wr_data_i[ASYNC_W-1:0];
            default:   ;
         endcase
      end
   end

   assign wr_fault_o = wr_en_i && (wr_sel_i == SEL_ID);
endmodule

// File: rtl/irq_level_eval.sv
module irq_level_eval
   import irq_level_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SW_MIN  = 4,
   parameter int SW_MAX  = 19,
   parameter int EXT_MIN = 20,
   parameter int EXT_MAX = 24,
   parameter int LVL_W   = 5,
   parameter int ASYNC_W = 4,
   localparam int SW_N   = SW_MAX - SW_MIN,
   localparam int EXT_N  = EXT_MAX - EXT_MIN,
   localparam int SUM_W  = EXT_MAX
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_sel_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [EXT_N-1:0]  ext_req_i,
   input  logic              strobe_i,
   output logic              take_o,
   output logic [SUM_W-1:0]  summary_o,
   output logic [LVL_W-1:0]  int_id_o,
   output logic [DATA_W-1:0] sw_req_o,
   output logic [LVL_W-1:0]  prio_o,
   output logic              wr_fault_o,
   output logic              async_err_o
);
   localparam int SW_IW  = (SW_N > 1) ? $clog2(SW_N) : 1;
   localparam int EXT_IW = (EXT_N > 1) ? $clog2(EXT_N) : 1;

   if (SW_N < 1 || EXT_N < 1) begin : g_bad_range
      $error("irq_level_eval: empty request range");
   end
   if (SW_MAX > DATA_W) begin : g_bad_data
      $error("irq_level_eval: software range exceeds data width");
   end
   if (EXT_MIN <= SW_N) begin : g_bad_overlap
      $error("irq_level_eval: external levels must exceed software levels");
   end
   if (EXT_MIN < SW_MAX) begin : g_bad_sumpos
      $error("irq_level_eval: external summary bits overlap software bits");
   end
   if (EXT_MAX - 1 >= (1 << LVL_W)) begin : g_bad_lvl
      $error("irq_level_eval: level width too small");
   end

   logic [DATA_W-1:0]  sw_q;
   logic [LVL_W-1:0]   prio_q;
   logic [ASYNC_W-1:0] async_q;

   irq_cfg_regs #(
      .DATA_W (DATA_W),
      .SW_MIN (SW_MIN),
      .SW_MAX (SW_MAX),
      .LVL_W  (LVL_W),
      .ASYNC_W(ASYNC_W)
   ) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_sel_i  (wr_sel_e'(wr_sel_i)),
      .wr_data_i (wr_data_i),
      .sw_q_o    (sw_q),
      .prio_q_o  (prio_q),
      .async_q_o (async_q),
      .wr_fault_o(wr_fault_o)
   );

   logic [SW_N-1:0]   sw_slice;
   logic              sw_any, ext_any;
   logic [SW_IW-1:0]  sw_idx;
   logic [EXT_IW-1:0] ext_idx;

   assign sw_slice = sw_q[SW_MAX-1:SW_MIN];

   irq_hi_encode #(.W(SW_N), .IDX_W(SW_IW)) u_sw_enc (
      .vec_i(sw_slice),
      .any_o(sw_any),
      .idx_o(sw_idx)
   );

   irq_hi_encode #(.W(EXT_N), .IDX_W(EXT_IW)) u_ext_enc (
      .vec_i(ext_req_i),
      .any_o(ext_any),
      .idx_o(ext_idx)
   );

   logic [LVL_W-1:0] lvl;
   logic [SUM_W-1:0] mask;

   always_comb begin
      if (ext_any) begin
         lvl = LVL_W'(EXT_MIN) + LVL_W'(ext_idx);
      end else if (sw_any) begin
         lvl = LVL_W'(sw_idx) + LVL_W'(1);
      end else begin
         lvl = '0;
      end
      mask = '0;
      mask[SW_MAX-1:SW_MIN]   = sw_slice;
      mask[EXT_MAX-1:EXT_MIN] = ext_req_i;
   end

   assign take_o = strobe_i && (lvl != '0) && (lvl > prio_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         summary_o <= '0;
         int_id_o  <= '0;
      end else if (take_o) begin
         summary_o <= mask;
         int_id_o  <= lvl;
      end
   end

   assign sw_req_o    = sw_q;
   assign prio_o      = prio_q;
   assign async_err_o = |async_q;
endmodule

// File: rtl/irq_level_eval_chk.sv
module irq_level_eval_chk #(
   parameter int DATA_W = 32,
   parameter int SW_MIN = 4,
   parameter int SW_MAX = 19,
   parameter int SUM_W  = 24,
   parameter int LVL_W  = 5
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              strobe_i,
   input logic              take_o,
   input logic [SUM_W-1:0]  summary_o,
   input logic [LVL_W-1:0]  int_id_o,
   input logic [DATA_W-1:0] sw_req_o,
   input logic [LVL_W-1:0]  prio_o,
   input logic              wr_fault_o
);
   logic [DATA_W-1:0] legal_sw;
   always_comb begin
      for (int i = 0; i < DATA_W; i++) legal_sw[i] = (i >= SW_MIN) && (i < SW_MAX);
   end

   // R4
   assert_take_needs_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> strobe_i);
   // R5: latched level beats the threshold that was in force
   assert_id_above_prio_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |=> int_id_o > $past(prio_o));
   assert_summary_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |=> summary_o != '0);
   // R6
   assert_status_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !take_o |=> ($stable(summary_o) && $stable(int_id_o)));
   // R7
   assert_sw_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_req_o & ~legal_sw) == '0);
   // R9
   assert_fault_no_id_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_fault_o && !take_o) |=> $stable(int_id_o));
endmodule

bind irq_level_eval irq_level_eval_chk #(
   .DATA_W(DATA_W), .SW_MIN(SW_MIN), .SW_MAX(SW_MAX), .SUM_W(SUM_W), .LVL_W(LVL_W)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .strobe_i  (strobe_i),
   .take_o    (take_o),
   .summary_o (summary_o),
   .int_id_o  (int_id_o),
   .sw_req_o  (sw_req_o),
   .prio_o    (prio_o),
   .wr_fault_o(wr_fault_o)
);

// File: tb/irq_level_eval_tb.sv
module irq_level_eval_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = '0;
   logic [3:0]  ext = '0;
   logic        strobe = 1'b0;
   logic        take;
   logic [23:0] summary;
   logic [4:0]  int_id;
   logic [31:0] sw_req;
   logic [4:0]  prio;
   logic        wr_fault;
   logic        async_err;

   int n_vec = 0;
   int n_bad = 0;
   logic [23:0] exp_sum = '0;
   logic [4:0]  exp_id = '0;

   always #10 clk = ~clk;

   irq_level_eval u_dut (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
      .wr_data_i(wr_data), .ext_req_i(ext), .strobe_i(strobe),
      .take_o(take), .summary_o(summary), .int_id_o(int_id),
      .sw_req_o(sw_req), .prio_o(prio), .wr_fault_o(wr_fault),
      .async_err_o(async_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // full evaluation: returns expected level/mask from requirements R1-style maths
   task automatic apply(input logic [31:0] swv, input logic [3:0] e, input logic [31:0] pv);
      logic [31:0] swm;
      logic [4:0]  lvl;
      logic [23:0] m;
      logic        tk;
      swm = swv & 32'h7fff0;
      lvl = '0; m = '0;
      for (int i = 4; i < 19; i++) if (swm[i]) begin lvl = 5'(i - 3); m[i] = 1'b1; end
      for (int j = 0; j < 4; j++) if (e[j]) begin lvl = 5'(20 + j); m[20 + j] = 1'b1; end
      tk = (lvl != 0) && (lvl > 5'(pv & 32'h1f));
      wr(2'd0, swv);
      check("R7", sw_req, swm);
      wr(2'd1, pv);
      check("R8", {27'd0, prio}, pv & 32'h1f);
      ext = e; strobe = 1'b1;
      #2;
      check("R4", {31'd0, take}, {31'd0, tk});
      @(negedge clk);
      strobe = 1'b0; ext = '0;
      if (tk) begin exp_sum = m; exp_id = lvl; end
      check(tk ? "R5/R1/R2/R3" : "R6", {8'd0, summary}, {8'd0, exp_sum});
      check(tk ? "R5/R1/R2" : "R6", {27'd0, int_id}, {27'd0, exp_id});
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11", {8'd0, summary}, 32'd0);
      check("R11", {27'd0, int_id}, 32'd0);
      check("R11", sw_req, 32'd0);
      check("R11", {27'd0, prio}, 32'd0);
      check("R11", {29'd0, take, wr_fault, async_err}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: no strobe means no take
      wr(2'd0, 32'h40000);
      ext = 4'hf; #2;
      check("R4", {31'd0, take}, 32'd0);
      ext = '0;

      // R1/R3/R7: every single data bit as software request, threshold 0
      for (int b = 0; b < 32; b++) apply(32'd1 << b, 4'h0, 32'd0);
      // R1/R2/R4/R8: threshold sweep against all external patterns and software mixes
      for (int p = 0; p < 40; p++) begin
         for (int e = 0; e < 16; e++) begin
            apply(32'h0, 4'(e), 32'(p));
            apply(32'h00410, 4'(e), 32'(p));
            apply(32'h7fff0 ^ 32'(p << 6), 4'(e), 32'(p));
            apply(32'hffffffff, 4'(e), 32'(p + 32'h20));
         end
      end

      // R9: write to read-only ID
      apply(32'h10, 4'h8, 32'd0);     // id = 23
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'h5; #2;
      check("R9", {31'd0, wr_fault}, 32'd1);
      @(negedge clk);
      wr_en = 1'b0; #2;
      check("R9", {31'd0, wr_fault}, 32'd0);
      check("R9", {27'd0, int_id}, 32'd23);
      check("R9", sw_req, 32'h10);

      // R10: trap-request register
      wr(2'd3, 32'h10);
      check("R10", {31'd0, async_err}, 32'd0);
      wr(2'd3, 32'h3);
      check("R10", {31'd0, async_err}, 32'd1);
      wr(2'd3, 32'h8);
      check("R10", {31'd0, async_err}, 32'd1);
      wr(2'd3, 32'h0);
      check("R10", {31'd0, async_err}, 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule